// File: doc/BRIEF.md
# Byte-Serial Register Access Port

This block lets an 8-bit strobed bus reach two 24-bit quantities: a preset value that the block holds and drives out, and a capture value that a neighbouring counter supplies. A data write places one bus byte into the preset. A data read returns one byte of the capture value. A byte pointer picks the byte, starting at the low byte, and steps forward after every data access, so three accesses in a row move a whole 24-bit word.

A write with the control/data select high is a command. The top three bits of the byte name the target register, and the other five bits go with it as an argument. The block sends the command out as a one-cycle valid pulse and also returns the byte pointer to the low byte. The bus has no wait states, so neither stream can be held back: the read byte must be ready while the read strobe is high, and the command pulse carries no ready input. A consumer must accept every command in the cycle it appears.

Top module: `byte_serial_port`

## Requirements
- R1: After reset, `preset_val` is 0, `cmd_valid` is 0, `bus_oe` is 0 and the byte pointer addresses byte 0.
- R2: A data write (`bus_sel`=1, `bus_ctl`=0, rising `bus_wr`) stores `bus_din` into the preset byte the pointer addresses. Byte k is bits 8k+7..8k. The new value appears on `preset_val` after the clock edge that sees the strobe rise.
- R3: The byte pointer steps 0, 1, 2 and back to 0. It steps once at the rise of every data write and once at the fall of every data read.
- R4: While `bus_sel`, `bus_rd` and not `bus_ctl` are all high, `bus_dout` shows byte k (bits 8k+7..8k) of `latch_val` in the same cycle, where k is the pointer.
- R5: `bus_oe` is 1 exactly while `bus_sel` and `bus_rd` are both 1. While `bus_oe` is 0, `bus_dout` is 0.
- R6: A control write (`bus_sel`=1, `bus_ctl`=1, rising `bus_wr`) raises `cmd_valid` for exactly one cycle. In that cycle `cmd_code` equals `bus_din[7:5]` and `cmd_arg` equals `bus_din[4:0]`. The write returns the pointer to byte 0 and leaves `preset_val` unchanged.
- R7: A strobe with `bus_sel`=0 is ignored. It changes neither the preset nor the pointer, and it issues no command.
- R8: A strobe counts as one access however many cycles it is held.
- R9: A control read drives `bus_oe`=1 with `bus_dout`=0 and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_ctl | input | 1 | 1 = control access, 0 = data access |
| bus_din | input | 8 | Write data byte |
| bus_dout | output | 8 | Read data byte |
| bus_oe | output | 1 | Enable for the external tri-state driver |
| latch_val | input | 24 | Capture value that data reads return |
| preset_val | output | 24 | Preset value that data writes assemble |
| cmd_valid | output | 1 | One-cycle command pulse, with no back-pressure |
| cmd_code | output | 3 | Register selected by the command |
| cmd_arg | output | 5 | Lower command bits |

## Verification
Read data is combinational. The bench samples `bus_dout` and `bus_oe` 1 ns after it changes the strobe, which is well before the next clock edge. A write result appears one edge after the strobe rise: the preset and `cmd_valid` are checked at the falling clock edge that follows. The bench checks that the pulse is gone one cycle later. The pointer moves at the edge after the strobe rise for a write, and at the edge after the strobe fall for a read. The bench never reads the pointer directly. It infers the pointer from which byte the next access hits.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  // Edge events derived from one strobe input.
  typedef struct packed {
    logic rise;
    logic fall;
  } strobe_ev_t;

  function automatic int ptr_width(input int nbytes);
    return (nbytes < 2) ? 1 : $clog2(nbytes);
  endfunction
endpackage

// File: rtl/bsp_edge.sv
module bsp_edge #(
  parameter int N = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              lvl,
  output bsp_pkg::strobe_ev_t [N-1:0] ev
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign ev[i].rise = lvl[i] & ~lvl_q[i];
    assign ev[i].fall = ~lvl[i] & lvl_q[i];

    // R8: a rise cannot repeat on the next cycle
    a_r8_one_rise: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i].rise |=> !ev[i].rise);
  end
endmodule

// File: rtl/bsp_ptr.sv
module bsp_ptr #(
  parameter int NBYTES = 3,
  localparam int PW = bsp_pkg::ptr_width(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clear,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr <= '0;
    else if (clear)    ptr <= '0;
    else if (step)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
  a_r6_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ptr == '0));
  a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(ptr));
endmodule

// File: rtl/bsp_preset.sv
module bsp_preset #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  localparam int PW = bsp_pkg::ptr_width(NBYTES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PW-1:0]            ptr,
  input  logic [BYTE_W-1:0]        din,
  output logic [NBYTES*BYTE_W-1:0] value
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        value[i*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && ptr == PW'(i))
        value[i*BYTE_W +: BYTE_W] <= din;
    end
  end

  // R7: without a data write the preset keeps its value
  a_r7_preset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(value));
endmodule

// File: rtl/byte_serial_port.sv
module byte_serial_port #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  parameter int CODE_W = 3,
  localparam int WORD_W = BYTE_W * NBYTES,
  localparam int ARG_W = BYTE_W - CODE_W,
  localparam int PW = bsp_pkg::ptr_width(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_ctl,
  input  logic [BYTE_W-1:0] bus_din,
  output logic [BYTE_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [WORD_W-1:0] latch_val,
  output logic [WORD_W-1:0] preset_val,
  output logic              cmd_valid,
  output logic [CODE_W-1:0] cmd_code,
  output logic [ARG_W-1:0]  cmd_arg
);
  bsp_pkg::strobe_ev_t [1:0] ev;
  logic [PW-1:0] ptr;
  logic wr_go, data_wr, ctl_wr, rd_armed, rd_done;

  bsp_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl({bus_wr, bus_rd}), .ev(ev)
  );

  assign wr_go   = ev[1].rise & bus_sel;
  assign data_wr = wr_go & ~bus_ctl;
  assign ctl_wr  = wr_go & bus_ctl;

  // A data read counts when it began selected; it completes on strobe fall.
  always_ff @(posedge clk) begin
    if (!rst_n)          rd_armed <= 1'b0;
    else if (ev[0].rise) rd_armed <= bus_sel & ~bus_ctl;
    else if (ev[0].fall) rd_armed <= 1'b0;
  end
  assign rd_done = ev[0].fall & rd_armed;

  bsp_ptr #(.NBYTES(NBYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step(data_wr | rd_done), .clear(ctl_wr), .ptr(ptr)
  );

  bsp_preset #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_preset (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .ptr(ptr), .din(bus_din),
    .value(preset_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_arg   <= '0;
    end else begin
      cmd_valid <= ctl_wr;
      if (ctl_wr) begin
        cmd_code <= bus_din[BYTE_W-1 -: CODE_W];
        cmd_arg  <= bus_din[ARG_W-1:0];
      end
    end
  end

  // Read path: byte mux on the pointer.
  logic [BYTE_W-1:0] rd_byte;
  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NBYTES; i++)
      if (ptr == PW'(i)) rd_byte = latch_val[i*BYTE_W +: BYTE_W];
  end

  assign bus_oe   = bus_sel & bus_rd;
  assign bus_dout = (bus_oe && !bus_ctl) ? rd_byte : '0;

  a_r6_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r5_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_dout == '0));
  a_r4_dout_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe) && $stable(latch_val) && $stable(bus_ctl) && $stable(ptr))
      |-> $stable(bus_dout));
  a_r7_no_cmd_unsel: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !cmd_valid);
endmodule

// File: tb/tb_byte_serial_port.sv
`timescale 1ns/1ps
module tb_byte_serial_port;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_rd, bus_wr, bus_ctl;
  logic [7:0] bus_din, bus_dout;
  logic bus_oe;
  logic [23:0] latch_val, preset_val;
  logic cmd_valid;
  logic [2:0] cmd_code;
  logic [4:0] cmd_arg;

  int errors = 0;
  int checks = 0;
  int ptr_m = 0;
  logic [23:0] preset_m = '0;
  bit done = 0;

  always #2 clk = ~clk;

  byte_serial_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ctl(bus_ctl), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .latch_val(latch_val), .preset_val(preset_val), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_arg(cmd_arg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [23:0] w, input int k);
    return w[k*8 +: 8];
  endfunction

  function automatic logic [23:0] put_byte(input logic [23:0] w, input int k,
                                           input logic [7:0] b);
    logic [23:0] r = w;
    r[k*8 +: 8] = b;
    return r;
  endfunction

  // Write access: strobe held for `hold` cycles.
  task automatic do_write(input bit sel, input bit ctl, input logic [7:0] d, input int hold);
    bus_sel = sel; bus_ctl = ctl; bus_din = d; bus_wr = 1'b1;
    @(negedge clk);
    if (sel && ctl) begin
      chk(cmd_valid === 1'b1, "R6 pulse", cmd_valid, 1);
      chk(cmd_code === d[7:5], "R6 code", cmd_code, d[7:5]);
      chk(cmd_arg === d[4:0], "R6 arg", cmd_arg, d[4:0]);
      ptr_m = 0;
    end else if (sel) begin
      preset_m = put_byte(preset_m, ptr_m, d);
      ptr_m = (ptr_m + 1) % 3;
    end else begin
      chk(cmd_valid === 1'b0, "R7 no cmd", cmd_valid, 0);
    end
    chk(preset_val === preset_m, "R2/R7 preset", preset_val, preset_m);
    for (int i = 1; i < hold; i++) begin
      @(negedge clk);
      chk(cmd_valid === 1'b0, "R8 held write", cmd_valid, 0);
    end
    bus_wr = 1'b0;
    @(negedge clk);
    chk(cmd_valid === 1'b0, "R6 pulse end", cmd_valid, 0);
    chk(preset_val === preset_m, "R8 preset after hold", preset_val, preset_m);
    bus_sel = 1'b0;
  endtask

  task automatic do_read(input bit sel, input bit ctl, input int hold);
    logic [7:0] exp;
    bus_sel = sel; bus_ctl = ctl; bus_rd = 1'b1;
    #1;
    chk(bus_oe === sel, "R5 oe", bus_oe, sel);
    exp = (sel && !ctl) ? byte_of(latch_val, ptr_m) : 8'h00;
    chk(bus_dout === exp, sel ? (ctl ? "R9 ctl read" : "R4 data byte") : "R5 idle dout",
        bus_dout, exp);
    @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      chk(bus_dout === exp, "R8 held read", bus_dout, exp);
      @(negedge clk);
    end
    bus_rd = 1'b0;
    #1;
    chk(bus_oe === 1'b0, "R5 oe off", bus_oe, 0);
    chk(bus_dout === 8'h00, "R5 dout off", bus_dout, 0);
    @(negedge clk);
    if (sel && !ctl) ptr_m = (ptr_m + 1) % 3;
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    rst_n = 1'b0; bus_sel = 0; bus_rd = 0; bus_wr = 0; bus_ctl = 0; bus_din = 0;
    latch_val = 24'hC3B2A1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(preset_val === 24'h0, "R1 preset", preset_val, 0);
    chk(cmd_valid === 1'b0, "R1 cmd", cmd_valid, 0);
    chk(bus_oe === 1'b0, "R1 oe", bus_oe, 0);
    do_read(1, 0, 0); // R1: first read hits byte 0

    ptr_m = 1;
    do_write(1, 1, 8'hA5, 1);   // R6 clears pointer
    do_write(1, 0, 8'h11, 1);   // R2, R3
    do_write(1, 0, 8'h22, 2);
    do_write(1, 0, 8'h33, 1);
    chk(preset_val === 24'h332211, "R2 full word", preset_val, 24'h332211);
    do_write(1, 0, 8'h44, 1);   // R3 wrap to byte 0
    chk(preset_val === 24'h332244, "R3 wrap", preset_val, 24'h332244);
    do_write(0, 0, 8'hEE, 2);   // R7 unselected write
    do_write(0, 1, 8'hFF, 1);   // R7 unselected control
    do_write(1, 0, 8'h55, 1);   // lands in byte 1
    chk(preset_val === 24'h335544, "R7 pointer untouched", preset_val, 24'h335544);
    do_write(1, 1, 8'h1F, 1);   // R6
    chk(preset_val === 24'h335544, "R6 preset kept", preset_val, 24'h335544);
    do_read(1, 0, 0);           // R4 byte 0
    do_read(1, 1, 1);           // R9 control read, no step
    do_read(0, 0, 1);           // R7/R5 unselected read
    do_read(1, 0, 5);           // R8 long read, byte 1
    do_read(1, 0, 0);           // byte 2
    do_read(1, 0, 0);           // R3 wrap byte 0
    do_write(1, 0, 8'h99, 6);   // R8 long write, byte 1
    chk(preset_val === 24'h339944, "R8 one step", preset_val, 24'h339944);

    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      bit sel = ($urandom_range(0, 9) != 0);
      int hold = $urandom_range(0, 3);
      latch_val = 24'($urandom);
      if (op < 4)      do_write(sel, 0, 8'($urandom), hold + 1);
      else if (op < 5) do_write(sel, 1, 8'($urandom), hold + 1);
      else if (op < 9) do_read(sel, 0, hold);
      else             do_read(sel, 1, hold);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule